// File: doc/BRIEF.md
# Dual Framebuffer Fetch Sequencer

This block reads pixel words from memory and pushes them into the pixel FIFO that feeds a raster output. It keeps two framebuffers. Each one is given by a word-aligned base byte address and an inclusive ceiling, which is the address of the buffer's last byte (base + size − 1). A mode input chooses between two behaviours. In the first, buffer 0 is fetched over and over. In the second, fetching alternates between buffer 0 and buffer 1. When a buffer has been fully fetched, the block pulses an end-of-frame event for that buffer. Software can then reload that buffer's addresses while the other buffer is being read.

On the memory side the block uses a request/grant read-burst handshake. A burst is `2^code` words long, up to 16 words. The last burst of a buffer is cut short so that no read passes the ceiling. A burst is requested only when the downstream FIFO reports enough free slots to take the whole burst. Each returned beat is pushed into the FIFO unchanged. A separate detector raises an underflow event whenever the output side asks for a pixel while the FIFO is empty.

Top module: `fbf_fetch_seq`

## Requirements
- R1: While reset is asserted, and after it is released with `enable` low, `rd_req`, `fifo_push`, `eof0`, `eof1` and `uflow` are all 0.
- R2: A full burst is `2^burst_code` words, so codes 0 to 4 give 1, 2, 4, 8 and 16 words. Codes 5 to 7 give 16 words.
- R3: Within a frame, the first request starts at the buffer's base address. Each later request's address equals the previous address plus 4 × its length.
- R4: The final burst of a frame is shortened to the words left up to the ceiling. A frame reads exactly (ceiling − base)/4 + 1 words, and no request covers a byte above the ceiling.
- R5: `rd_req` is asserted only when `fifo_free` is at least `rd_len`.
- R6: With `dual_mode` = 0, every frame fetches buffer 0, and only `eof0` pulses.
- R7: With `dual_mode` = 1, frames alternate between buffer 0 and buffer 1, starting with buffer 0. The event for the finished buffer (`eof0` or `eof1`) is high for exactly one cycle, in the cycle after the edge that accepts the frame's last beat. The two events are never high together.
- R8: A buffer's base and ceiling are captured when that buffer starts. Rewriting them while the buffer is being fetched has no effect on that frame. The new values apply the next time that buffer starts.
- R9: Every beat accepted with `rd_valid` during a granted burst produces one `fifo_push` with `fifo_data` equal to `rd_data`, in order. No push occurs outside a burst.
- R10: While `enable` is low, and in the cycle after it falls, there are no requests and no pushes. After re-enabling, fetching restarts at buffer 0's base address.
- R11: `uflow` is high in the cycle after any cycle in which `pix_need` and `fifo_empty` are both high, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run fetching; low abandons the frame and selects buffer 0 |
| dual_mode | input | 1 | 0: repeat buffer 0; 1: alternate buffers 0 and 1 |
| burst_code | input | CODE_W | Burst length exponent |
| fb0_base | input | 32 | Buffer 0 first byte address (word aligned) |
| fb0_ceil | input | 32 | Buffer 0 last byte address |
| fb1_base | input | 32 | Buffer 1 first byte address (word aligned) |
| fb1_ceil | input | 32 | Buffer 1 last byte address |
| fifo_free | input | FREE_W | Free word slots in the pixel FIFO |
| fifo_push | output | 1 | Push one word into the FIFO |
| fifo_data | output | 32 | Word being pushed |
| rd_req | output | 1 | Read burst request |
| rd_addr | output | 32 | Burst start byte address |
| rd_len | output | MAX_CODE+1 | Burst length in words |
| rd_gnt | input | 1 | Request accepted this cycle |
| rd_valid | input | 1 | Read data beat valid |
| rd_data | input | 32 | Read data beat |
| pix_need | input | 1 | Output side wants a pixel this cycle |
| fifo_empty | input | 1 | Pixel FIFO is empty |
| eof0 | output | 1 | Buffer 0 finished (one-cycle pulse) |
| eof1 | output | 1 | Buffer 1 finished (one-cycle pulse) |
| uflow | output | 1 | FIFO underflow event |

## Verification
The fetch sequence is exercised with buffer sizes that divide evenly by the burst, sizes that leave a short final burst, and single-word buffers. Together these separate a correct ceiling clip from an off-by-one that reads one word too many or too few. Burst codes 0, 4 and an out-of-range code show whether the length decode and its clamp are correct. Single and alternating modes, with a rewrite of one buffer's addresses in the middle of its frame and a rewrite at the other buffer's end-of-frame, show when the addresses are captured. Random FIFO free counts, grant delays and beat gaps check the room-before-request rule and beat ordering, and a disable in the middle of a burst checks the restart at buffer 0.

// File: rtl/fbf_pkg.sv
package fbf_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_REQ, ST_DATA} fetch_st_e;

  // words in a full burst for an exponent code, clamped to the largest code
  function automatic logic [ADDR_W-1:0] burst_words(input int code, input int max_code);
    int c;
    c = (code > max_code) ? max_code : code;
    return ADDR_W'(1) << c;
  endfunction

  // words from addr up to and including the word holding ceil
  function automatic logic [ADDR_W-1:0] words_to_ceiling(input logic [ADDR_W-1:0] addr,
                                                        input logic [ADDR_W-1:0] ceil);
    return ((ceil - addr) >> 2) + ADDR_W'(1);
  endfunction
endpackage

// File: rtl/fbf_len_calc.sv
module fbf_len_calc
  import fbf_pkg::*;
#(
  parameter int MAX_CODE = 4,
  parameter int CODE_W   = 3,
  parameter int LEN_W    = MAX_CODE + 1
) (
  input  logic [CODE_W-1:0] code,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] ceil,
  output logic [LEN_W-1:0]  len,
  output logic              last
);
  logic [ADDR_W-1:0] full_w;
  logic [ADDR_W-1:0] left_w;

  always_comb begin
    full_w = burst_words(int'(code), MAX_CODE);
    left_w = words_to_ceiling(addr, ceil);
    if (left_w <= full_w) begin
      len  = left_w[LEN_W-1:0];
      last = 1'b1;
    end else begin
      len  = full_w[LEN_W-1:0];
      last = 1'b0;
    end
  end
endmodule

// File: rtl/fbf_uflow_det.sv
module fbf_uflow_det (
  input  logic clk,
  input  logic rst_n,
  input  logic pix_need,
  input  logic fifo_empty,
  output logic uflow
);
  always_ff @(posedge clk) begin
    if (!rst_n) uflow <= 1'b0;
    else        uflow <= pix_need & fifo_empty;
  end

  p_uflow_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_need && fifo_empty) |=> uflow);
endmodule

// File: rtl/fbf_fetch_seq.sv
module fbf_fetch_seq
  import fbf_pkg::*;
#(
  parameter int MAX_CODE = 4,
  parameter int CODE_W   = 3,
  parameter int FREE_W   = 6,
  parameter int LEN_W    = MAX_CODE + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              dual_mode,
  input  logic [CODE_W-1:0] burst_code,
  input  logic [31:0]       fb0_base,
  input  logic [31:0]       fb0_ceil,
  input  logic [31:0]       fb1_base,
  input  logic [31:0]       fb1_ceil,
  input  logic [FREE_W-1:0] fifo_free,
  output logic              fifo_push,
  output logic [31:0]       fifo_data,
  output logic              rd_req,
  output logic [31:0]       rd_addr,
  output logic [LEN_W-1:0]  rd_len,
  input  logic              rd_gnt,
  input  logic              rd_valid,
  input  logic [31:0]       rd_data,
  input  logic              pix_need,
  input  logic              fifo_empty,
  output logic              eof0,
  output logic              eof1,
  output logic              uflow
);
  localparam int NBUF = 2;

  fetch_st_e         st_q;
  logic              cur_buf_q;
  logic [ADDR_W-1:0] addr_q, ceil_q;
  logic [LEN_W-1:0]  beats_q;
  logic              last_q;
  logic [NBUF-1:0]   eof_q;

  // named internal events
  logic [LEN_W-1:0] calc_len;
  logic             calc_last;
  logic             room_ok;
  logic             beat_acc;
  logic             burst_end;

  fbf_len_calc #(.MAX_CODE(MAX_CODE), .CODE_W(CODE_W), .LEN_W(LEN_W)) u_len (
    .code (burst_code),
    .addr (addr_q),
    .ceil (ceil_q),
    .len  (calc_len),
    .last (calc_last)
  );

  fbf_uflow_det u_uflow (
    .clk        (clk),
    .rst_n      (rst_n),
    .pix_need   (pix_need),
    .fifo_empty (fifo_empty),
    .uflow      (uflow)
  );

  assign room_ok   = 32'(fifo_free) >= 32'(calc_len);
  assign rd_req    = enable && (st_q == ST_REQ) && room_ok;
  assign rd_addr   = addr_q;
  assign rd_len    = calc_len;
  assign beat_acc  = enable && (st_q == ST_DATA) && rd_valid;
  assign burst_end = beat_acc && (beats_q == LEN_W'(1));
  assign fifo_push = beat_acc;
  assign fifo_data = rd_data;
  assign eof0      = eof_q[0];
  assign eof1      = eof_q[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      cur_buf_q <= 1'b0;
      addr_q    <= '0;
      ceil_q    <= '0;
      beats_q   <= '0;
      last_q    <= 1'b0;
      eof_q     <= '0;
    end else begin
      eof_q <= '0;
      if (!enable) begin
        st_q      <= ST_IDLE;
        cur_buf_q <= 1'b0;
      end else begin
        case (st_q)
          ST_IDLE: st_q <= ST_START;
          ST_START: begin
            addr_q <= cur_buf_q ? fb1_base : fb0_base;
            ceil_q <= cur_buf_q ? fb1_ceil : fb0_ceil;
            st_q   <= ST_REQ;
          end
          ST_REQ: begin
            if (rd_req && rd_gnt) begin
              beats_q <= calc_len;
              last_q  <= calc_last;
              addr_q  <= addr_q + (ADDR_W'(calc_len) << 2);
              st_q    <= ST_DATA;
            end
          end
          default: begin
            if (beat_acc) beats_q <= beats_q - LEN_W'(1);
            if (burst_end) begin
              if (last_q) begin
                eof_q[cur_buf_q] <= 1'b1;
                cur_buf_q        <= dual_mode & ~cur_buf_q;
                st_q             <= ST_START;
              end else begin
                st_q <= ST_REQ;
              end
            end
          end
        endcase
      end
    end
  end

  p_req_fits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (32'(fifo_free) >= 32'(rd_len)));

  p_len_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (rd_len != '0) && (32'(rd_len) <= (32'(1) << MAX_CODE)));

  p_within_ceil_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> ({1'b0, rd_addr} + {1'b0, 32'(rd_len) << 2} - 33'd1) <= {1'b0, ceil_q});

  p_eof_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({eof0, eof1}));

  p_quiet_after_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!rd_req && !fifo_push));
endmodule

// File: tb/fbf_fetch_seq_tb.sv
module fbf_fetch_seq_tb;
  localparam int FREE_W = 6;
  localparam int LEN_W  = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, dual_mode = 1'b0;
  logic [2:0] burst_code = '0;
  logic [31:0] fb0_base = '0, fb0_ceil = '0, fb1_base = '0, fb1_ceil = '0;
  logic [FREE_W-1:0] fifo_free = '0;
  logic fifo_push;
  logic [31:0] fifo_data;
  logic rd_req;
  logic [31:0] rd_addr;
  logic [LEN_W-1:0] rd_len;
  logic rd_gnt = 1'b0, rd_valid = 1'b0;
  logic [31:0] rd_data = '0;
  logic pix_need = 1'b0, fifo_empty = 1'b0;
  logic eof0, eof1, uflow;

  always #4 clk = ~clk;

  fbf_fetch_seq u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .dual_mode(dual_mode),
    .burst_code(burst_code), .fb0_base(fb0_base), .fb0_ceil(fb0_ceil),
    .fb1_base(fb1_base), .fb1_ceil(fb1_ceil), .fifo_free(fifo_free),
    .fifo_push(fifo_push), .fifo_data(fifo_data), .rd_req(rd_req),
    .rd_addr(rd_addr), .rd_len(rd_len), .rd_gnt(rd_gnt), .rd_valid(rd_valid),
    .rd_data(rd_data), .pix_need(pix_need), .fifo_empty(fifo_empty),
    .eof0(eof0), .eof1(eof1), .uflow(uflow)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  // model state
  bit m_buf = 0, m_need_load = 1, in_burst = 0, m_last = 0;
  logic [31:0] m_addr = 0, m_ceil = 0, m_data_addr = 0;
  int m_beats = 0, eofs_seen = 0;
  bit exp_e0 = 0, exp_e1 = 0, exp_uf = 0;
  bit rw_mid = 0, rw_at_eof1 = 0, first_after_on = 0;
  logic [31:0] rw_base = 0, rw_ceil = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int exp_full(input int code);
    return 1 << ((code > 4) ? 4 : code);
  endfunction

  function automatic int exp_left(input logic [31:0] a, input logic [31:0] c);
    return int'((c - a) / 4) + 1;
  endfunction

  task automatic cycle();
    int full, left, elen;
    @(negedge clk);
    chk({eof0, eof1} == {exp_e0, exp_e1}, dual_mode ? "R7" : "R6", "eof pair",
        {eof0, eof1}, {exp_e0, exp_e1});
    chk(uflow == exp_uf, "R11", "uflow", uflow, exp_uf);
    if (eof0 || eof1) eofs_seen++;
    if (eof1 && rw_at_eof1) begin
      fb1_base = rw_base; fb1_ceil = rw_ceil; rw_at_eof1 = 0;
    end
    exp_e0 = 0; exp_e1 = 0;
    rd_gnt = 0; rd_valid = 0;
    pix_need = ($urandom % 2) == 1;
    fifo_empty = ($urandom % 3) == 0;
    exp_uf = pix_need && fifo_empty;
    fifo_free = FREE_W'($urandom_range(0, 20));
    if (!enable) begin
      #1;
      chk(!rd_req && !fifo_push, "R10", "req/push while off", {rd_req, fifo_push}, 0);
    end else if (in_burst) begin
      if ($urandom % 4 != 0) begin
        rd_valid = 1; rd_data = m_data_addr;
        #1;
        chk(fifo_push && fifo_data == m_data_addr, "R9", "push data", fifo_data, m_data_addr);
        m_data_addr += 4; m_beats--;
        if (m_beats == 0) begin
          in_burst = 0;
          if (m_last) begin
            if (m_buf) exp_e1 = 1; else exp_e0 = 1;
            m_buf = dual_mode ? ~m_buf : 1'b0;
            m_need_load = 1;
          end
        end
      end else begin
        #1;
        chk(!fifo_push, "R9", "push without beat", fifo_push, 0);
      end
    end else begin
      #1;
      chk(!fifo_push, "R9", "push outside burst", fifo_push, 0);
      if (rd_req) begin
        if (m_need_load) begin
          m_addr = m_buf ? fb1_base : fb0_base;
          m_ceil = m_buf ? fb1_ceil : fb0_ceil;
          m_need_load = 0;
          chk(rd_addr == m_addr, first_after_on ? "R10" : "R8", "frame start addr", rd_addr, m_addr);
          first_after_on = 0;
          if (rw_mid && !m_buf) begin
            fb0_base = fb0_base + 32'h100; fb0_ceil = fb0_ceil + 32'h100; rw_mid = 0;
          end
        end else begin
          chk(rd_addr == m_addr, "R3", "burst addr", rd_addr, m_addr);
        end
        full = exp_full(int'(burst_code));
        left = exp_left(m_addr, m_ceil);
        elen = (left < full) ? left : full;
        chk(int'(rd_len) == elen, (left < full) ? "R4" : "R2", "burst len", rd_len, elen);
        chk(int'(fifo_free) >= int'(rd_len), "R5", "room", fifo_free, rd_len);
        if ($urandom % 3 != 0) begin
          rd_gnt = 1; in_burst = 1; m_beats = elen; m_data_addr = m_addr;
          m_last = (elen == left); m_addr = m_addr + 32'(elen * 4);
        end
      end
    end
  endtask

  task automatic run_frames(input int n);
    int target;
    target = eofs_seen + n;
    for (int i = 0; i < 20000 && eofs_seen < target; i++) cycle();
    chk(eofs_seen >= target, "R7", "frames completed", eofs_seen, target);
  endtask

  task automatic turn_on();
    m_buf = 0; m_need_load = 1; in_burst = 0; first_after_on = 1;
    enable = 1;
  endtask

  task automatic turn_off();
    rd_valid = 0; rd_gnt = 0; enable = 0;
    in_burst = 0; m_buf = 0; m_need_load = 1; exp_e0 = 0; exp_e1 = 0;
  endtask

  task automatic set_buf(input int b, input logic [31:0] base, input int words);
    if (b == 0) begin fb0_base = base; fb0_ceil = base + 32'(words * 4) - 1; end
    else begin fb1_base = base; fb1_ceil = base + 32'(words * 4) - 1; end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!rd_req && !fifo_push && !eof0 && !eof1 && !uflow, "R1", "outputs in reset",
        {rd_req, fifo_push, eof0, eof1, uflow}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!rd_req && !fifo_push && !eof0 && !eof1 && !uflow, "R1", "outputs idle",
        {rd_req, fifo_push, eof0, eof1, uflow}, 0);

    // R6: single mode, 10 words with 4-word bursts -> 4,4,2
    dual_mode = 0; burst_code = 3'd2;
    set_buf(0, 32'h1000, 10); set_buf(1, 32'h8000, 3);
    turn_on(); run_frames(3);

    // R7: alternate, unequal sizes, mid-frame rewrite of buffer 0 (R8)
    turn_off(); cycle(); cycle();
    dual_mode = 1; burst_code = 3'd3;
    set_buf(0, 32'h2000, 13); set_buf(1, 32'h3000, 5);
    rw_mid = 1;
    turn_on(); run_frames(5);
    // R8: rewrite buffer 1 at its own end of frame
    rw_base = 32'h5000; rw_ceil = 32'h5000 + 7*4 - 1; rw_at_eof1 = 1;
    run_frames(4);

    // R4: single-word buffers at codes 0 and 4
    turn_off(); cycle();
    burst_code = 3'd0; set_buf(0, 32'h4000, 1); set_buf(1, 32'h4100, 1);
    turn_on(); run_frames(4);
    turn_off(); cycle();
    burst_code = 3'd4;
    turn_on(); run_frames(4);

    // R2: out-of-range code clamps to 16; 40 words -> 16,16,8
    turn_off(); cycle();
    dual_mode = 0; burst_code = 3'd6; set_buf(0, 32'h6000, 40);
    turn_on(); run_frames(2);

    // R10: disable inside a burst, stay off, restart at buffer 0
    dual_mode = 1; set_buf(1, 32'h7000, 20);
    for (int i = 0; i < 400 && !in_burst; i++) cycle();
    cycle();
    turn_off();
    for (int i = 0; i < 6; i++) cycle();
    turn_on(); run_frames(3);

    // random configurations
    for (int k = 0; k < 12; k++) begin
      turn_off(); cycle();
      dual_mode = 1'($urandom % 2);
      burst_code = 3'($urandom % 8);
      set_buf(0, 32'h10000 + 32'($urandom_range(0, 255) * 4), $urandom_range(1, 40));
      set_buf(1, 32'h20000 + 32'($urandom_range(0, 255) * 4), $urandom_range(1, 40));
      turn_on(); run_frames(3);
    end

    turn_off(); cycle(); cycle();
    done = 1;
    summary();
    $finish;
  end
endmodule